// File: doc/BRIEF.md
# Dual-Mode Serial Control Receiver

This block is a write-only serial slave that takes control bytes from a host controller. It watches a clock line, a data line and a separate enable line. It recognises framing in two bus styles. On a three-wire bus, edges on the enable line mark the start and the end of a transfer. On an ordinary two-wire I2C bus, the enable line is tied to the data line, and data-line edges do the same job. The receiver accepts both at once, with no mode input: a falling edge on either framing line while the clock is high opens a transfer, and a rising edge closes it.

All three bus lines are oversampled by a fast system clock through synchronisers. The first byte of each transfer is compared with the device address, one bit of which comes from a strap input. When the address matches, the block acknowledges that byte and every later one by pulling the data line low for the ninth clock. Each later byte is then handed to the core logic with a one-cycle strobe. Without a match, the block stays silent until the next start.

Top module: `ctrl_bus_slave`

## Requirements
- R1: After reset, `sda_drive_n` is 1 (data line released) and `rx_valid` is 0.
- R2: A start is a 1-to-0 edge, and a stop a 0-to-1 edge, on either `sda_i` or `sen_i` while `scl_i` is high. A three-wire host (enable line separate) and a two-wire host (enable tied to data) are both served with no configuration.
- R3: The first byte after a start is taken MSB first. It matches only when its bits 7..0 are 1,0,0,0,1,0,A,0, where A is the level of `addr_sel`. With `addr_sel`=0 that is 0x88, and with `addr_sel`=1 it is 0x8A. A byte with bit 0 set never matches.
- R4: After a matching address byte, and after every data byte that follows it, `sda_drive_n` is 0 for the whole high phase of the ninth clock. It is back to 1 within a few system cycles after that clock falls.
- R5: After a match, any number of data bytes, sent MSB first, appear on `rx_data` in the order they were sent.
- R6: `rx_valid` is high for exactly one cycle per data byte. The pulse falls after the eighth clock falling edge and before the ninth clock rising edge.
- R7: After a non-matching address byte there is no acknowledge and no `rx_valid` until the next start.
- R8: A start in the middle of a byte drops the partial byte and begins address reception again.
- R9: A stop returns the block to idle and drops any partial byte. Bytes clocked after a stop and without a new start are neither acknowledged nor delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 16 times the bus bit rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_sel | input | 1 | Strap level placed in the selectable address bit |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sen_i | input | 1 | Framing enable line (tied to data on a two-wire bus) |
| sda_drive_n | output | 1 | Active-low pull-down enable for the data line |
| rx_data | output | 8 | Last data byte received |
| rx_valid | output | 1 | One-cycle strobe for a new `rx_data` byte |

## Verification
The bench builds the block with its default parameters: 8-bit bytes, base address 0x88 with the strap in bit 1, and two synchroniser stages. It drives `addr_sel` at both levels, so both device addresses and their mismatches come up. It runs a bus phase of eight system cycles against the three-cycle detection latency. That places the acknowledge pull and its release inside the clock-low phase, where they can be checked at the bus level. Two-wire and three-wire transfers are interleaved at random, so framing on either line is exercised right after the other.

// File: rtl/cbs_pkg.sv
package cbs_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ADDR = 2'd1,
    ST_DATA = 2'd2,
    ST_SKIP = 2'd3
  } rx_state_e;
endpackage

// File: rtl/cbs_rst_sync.sv
module cbs_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/cbs_line_sync.sv
module cbs_line_sync #(
  parameter int LINES  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] raw_i,
  output logic [LINES-1:0] sync_o
);
  // Bus lines idle high, so the chain resets to ones: no false edge at release.
  logic [STAGES-1:0][LINES-1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= '1;
    else        stage_q <= {stage_q[STAGES-2:0], raw_i};
  end

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/cbs_cond_detect.sv
module cbs_cond_detect #(
  parameter int FRAME_LINES = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   scl_s,
  input  logic [FRAME_LINES-1:0] frame_s,
  output logic                   start_o,
  output logic                   stop_o,
  output logic                   scl_rise_o,
  output logic                   scl_fall_o
);
  logic                   scl_prev_q;
  logic [FRAME_LINES-1:0] frame_prev_q;
  logic [FRAME_LINES-1:0] fall_v;
  logic [FRAME_LINES-1:0] rise_v;
  logic                   scl_held_high;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_prev_q   <= 1'b1;
      frame_prev_q <= '1;
    end else begin
      scl_prev_q   <= scl_s;
      frame_prev_q <= frame_s;
    end
  end

  // One edge detector per framing line; any line may open or close a transfer.
  for (genvar f = 0; f < FRAME_LINES; f++) begin : g_frame
    assign fall_v[f] = frame_prev_q[f] & ~frame_s[f];
    assign rise_v[f] = ~frame_prev_q[f] & frame_s[f];
  end

  assign scl_held_high = scl_s & scl_prev_q;
  assign start_o       = scl_held_high & (|fall_v);
  assign stop_o        = scl_held_high & (|rise_v);
  assign scl_rise_o    = scl_s & ~scl_prev_q;
  assign scl_fall_o    = ~scl_s & scl_prev_q;
endmodule

// File: rtl/cbs_protocol.sv
module cbs_protocol
  import cbs_pkg::*;
#(
  parameter int                DATA_W       = 8,
  parameter logic [DATA_W-1:0] ADDR_BASE    = DATA_W'(8'h88),
  parameter int                ADDR_PIN_POS = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              sda_bit_i,
  input  logic              addr_sel_i,
  output rx_state_e         state_o,
  output logic              pull_o,
  output logic [DATA_W-1:0] data_o,
  output logic              valid_o
);
  localparam int              CNT_W    = $clog2(DATA_W + 2);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DATA_W);
  localparam logic [CNT_W-1:0] CNT_ACK  = CNT_W'(DATA_W + 1);

  rx_state_e         state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [DATA_W-1:0] shift_q, shift_d;
  logic              pull_q, pull_d;
  logic [DATA_W-1:0] data_q;
  logic              valid_q;
  logic              data_en;
  logic [DATA_W-1:0] addr_match;

  always_comb begin
    addr_match               = ADDR_BASE;
    addr_match[ADDR_PIN_POS] = addr_sel_i;
  end

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    shift_d = shift_q;
    pull_d  = pull_q;
    data_en = 1'b0;
    if (start_i) begin
      state_d = ST_ADDR;
      cnt_d   = '0;
      pull_d  = 1'b0;
    end else if (stop_i) begin
      state_d = ST_IDLE;
      cnt_d   = '0;
      pull_d  = 1'b0;
    end else if (state_q == ST_ADDR || state_q == ST_DATA) begin
      if (scl_rise_i) begin
        if (cnt_q < CNT_LAST) begin
          shift_d = {shift_q[DATA_W-2:0], sda_bit_i};
          cnt_d   = cnt_q + 1'b1;
        end else if (cnt_q == CNT_LAST) begin
          cnt_d = CNT_ACK;
        end
      end else if (scl_fall_i) begin
        if (cnt_q == CNT_LAST) begin
          if (state_q == ST_ADDR) begin
            if (shift_q == addr_match) begin
              pull_d  = 1'b1;
              state_d = ST_DATA;
            end else begin
              state_d = ST_SKIP;
            end
          end else begin
            pull_d  = 1'b1;
            data_en = 1'b1;
          end
        end else if (cnt_q == CNT_ACK) begin
          pull_d = 1'b0;
          cnt_d  = '0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      shift_q <= '0;
      pull_q  <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      shift_q <= shift_d;
      pull_q  <= pull_d;
      valid_q <= data_en;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       data_q <= '0;
    else if (data_en) data_q <= shift_q;
  end

  assign state_o = state_q;
  assign pull_o  = pull_q;
  assign data_o  = data_q;
  assign valid_o = valid_q;
endmodule

// File: rtl/ctrl_bus_slave.sv
module ctrl_bus_slave
  import cbs_pkg::*;
#(
  parameter int                DATA_W       = 8,
  parameter logic [DATA_W-1:0] ADDR_BASE    = DATA_W'(8'h88),
  parameter int                ADDR_PIN_POS = 1,
  parameter int                SYNC_STAGES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr_sel,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              sen_i,
  output logic              sda_drive_n,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid
);
  localparam int LINES       = 3;
  localparam int FRAME_LINES = LINES - 1;

  logic             rst_n_s;
  logic [LINES-1:0] lines_s;
  logic             scl_s;
  logic             start_w;
  logic             stop_w;
  logic             scl_rise_w;
  logic             scl_fall_w;
  logic             pull_w;
  rx_state_e        state_w;

  cbs_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_n_s)
  );

  // Line order: bit 0 clock, bit 1 data, bit 2 enable.
  cbs_line_sync #(.LINES(LINES), .STAGES(SYNC_STAGES)) u_line_sync (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .raw_i  ({sen_i, sda_i, scl_i}),
    .sync_o (lines_s)
  );

  assign scl_s = lines_s[0];

  cbs_cond_detect #(.FRAME_LINES(FRAME_LINES)) u_cond (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .scl_s      (scl_s),
    .frame_s    (lines_s[LINES-1:1]),
    .start_o    (start_w),
    .stop_o     (stop_w),
    .scl_rise_o (scl_rise_w),
    .scl_fall_o (scl_fall_w)
  );

  cbs_protocol #(
    .DATA_W       (DATA_W),
    .ADDR_BASE    (ADDR_BASE),
    .ADDR_PIN_POS (ADDR_PIN_POS)
  ) u_proto (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .start_i    (start_w),
    .stop_i     (stop_w),
    .scl_rise_i (scl_rise_w),
    .scl_fall_i (scl_fall_w),
    .sda_bit_i  (lines_s[1]),
    .addr_sel_i (addr_sel),
    .state_o    (state_w),
    .pull_o     (pull_w),
    .data_o     (rx_data),
    .valid_o    (rx_valid)
  );

  assign sda_drive_n = ~pull_w;
endmodule

// File: rtl/cbs_checker.sv
module cbs_checker
  import cbs_pkg::*;
(
  input logic      clk,
  input logic      rst_n,
  input logic      scl_s,
  input logic      start_w,
  input logic      stop_w,
  input logic      sda_drive_n,
  input logic      rx_valid,
  input rx_state_e state_w
);
  p_valid_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  p_valid_with_ack_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> !sda_drive_n);

  p_pull_on_low_clock_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sda_drive_n) |-> !scl_s);

  p_start_restarts_r8: assert property (@(posedge clk) disable iff (!rst_n)
    start_w |=> (state_w == ST_ADDR && sda_drive_n));

  p_stop_idles_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_w && !start_w) |=> (state_w == ST_IDLE && sda_drive_n));

  p_skip_silent_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_w == ST_SKIP) |-> (sda_drive_n && !rx_valid));

  p_idle_silent_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_w == ST_IDLE) |-> (sda_drive_n && !rx_valid));
endmodule

bind ctrl_bus_slave cbs_checker u_cbs_checker (
  .clk         (clk),
  .rst_n       (rst_n_s),
  .scl_s       (scl_s),
  .start_w     (start_w),
  .stop_w      (stop_w),
  .sda_drive_n (sda_drive_n),
  .rx_valid    (rx_valid),
  .state_w     (state_w)
);

// File: tb/ctrl_bus_slave_bench.sv
`timescale 1ns/1ps
module ctrl_bus_slave_bench;
  localparam int P = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       addr_sel = 1'b0;
  logic       scl_m = 1'b1;
  logic       sda_m = 1'b1;
  logic       sen_m = 1'b1;
  logic       mode3 = 1'b0;
  logic       sda_drive_n;
  logic [7:0] rx_data;
  logic       rx_valid;
  logic       sda_bus;
  logic       sen_bus;

  int n_chk  = 0;
  int n_fail = 0;
  bit finished = 1'b0;
  bit ack_win = 1'b0;
  bit prev_v = 1'b0;
  logic [7:0] got_q[$];
  logic [7:0] exp_q[$];
  logic [7:0] pay[8];

  always #4 clk = ~clk;

  assign sda_bus = sda_m & sda_drive_n;
  assign sen_bus = mode3 ? sen_m : sda_bus;

  ctrl_bus_slave u_ctrl_bus_slave (
    .clk         (clk),
    .rst_n       (rst_n),
    .addr_sel    (addr_sel),
    .scl_i       (scl_m),
    .sda_i       (sda_bus),
    .sen_i       (sen_bus),
    .sda_drive_n (sda_drive_n),
    .rx_data     (rx_data),
    .rx_valid    (rx_valid)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] dev_addr(input logic a);
    return {4'b1000, 1'b1, 1'b0, a, 1'b0};
  endfunction

  // Strobe monitor: one-cycle pulses inside the acknowledge window (R6).
  always @(negedge clk) begin
    if (rst_n) begin
      if (rx_valid) begin
        chk(!prev_v, "R6 strobe width", 1, 0);
        chk(ack_win, "R6 strobe timing", 0, 1);
        got_q.push_back(rx_data);
      end
      prev_v <= rx_valid;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    scl_m = 1'b0; tick(P);
    sda_m = 1'b1; sen_m = 1'b1; tick(P);
    scl_m = 1'b1; tick(P);
    if (mode3) sen_m = 1'b0; else sda_m = 1'b0;
    tick(P);
    scl_m = 1'b0; tick(P);
    if (mode3) begin sen_m = 1'b1; tick(P); end
  endtask

  task automatic bus_stop();
    if (mode3) sen_m = 1'b0; else sda_m = 1'b0;
    tick(P);
    scl_m = 1'b1; tick(P);
    if (mode3) sen_m = 1'b1; else sda_m = 1'b1;
    tick(P);
  endtask

  task automatic send_bits(input logic [7:0] v, input int n);
    for (int i = 0; i < n; i++) begin
      sda_m = v[7-i]; tick(P);
      scl_m = 1'b1;   tick(P);
      scl_m = 1'b0;
      if (i == 7) ack_win = 1'b1;
      tick(P);
    end
  endtask

  task automatic send_byte(input logic [7:0] v, output bit acked);
    send_bits(v, 8);
    sda_m = 1'b1; tick(P);
    scl_m = 1'b1; ack_win = 1'b0; tick(P/2);
    acked = (sda_bus == 1'b0);
    tick(P/2);
    scl_m = 1'b0; tick(P);
    chk(sda_drive_n == 1'b1, "R4 release after ninth clock", sda_drive_n, 1);
  endtask

  task automatic compare_rx(input string req);
    chk(got_q.size() == exp_q.size(), req, got_q.size(), exp_q.size());
    if (got_q.size() == exp_q.size())
      foreach (exp_q[i]) chk(got_q[i] == exp_q[i], req, got_q[i], exp_q[i]);
    got_q.delete();
    exp_q.delete();
  endtask

  // One framed write with a bench-side model of match and acknowledge.
  task automatic xfer(input bit m3, input bit a, input logic [7:0] ab, input int nb);
    bit match;
    bit ack;
    mode3 = m3; addr_sel = a; tick(P);
    match = (ab == dev_addr(a));
    bus_start();
    send_byte(ab, ack);
    chk(ack == match, m3 ? "R3 address ack (R2 three-wire)" : "R3 address ack (R2 two-wire)", ack, match);
    for (int i = 0; i < nb; i++) begin
      send_byte(pay[i], ack);
      chk(ack == match, match ? "R4 data ack" : "R7 no data ack", ack, match);
      if (match) exp_q.push_back(pay[i]);
    end
    bus_stop();
    tick(P);
    compare_rx(match ? "R5 delivered bytes" : "R7 nothing delivered");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    bit ack;
    int unsigned seed_v;
    seed_v = $urandom(32'd20240607);
    tick(5);
    chk(sda_drive_n == 1'b1, "R1 released in reset", sda_drive_n, 1);
    rst_n = 1'b1;
    tick(6);
    chk(sda_drive_n == 1'b1, "R1 released after reset", sda_drive_n, 1);
    chk(rx_valid == 1'b0, "R1 no strobe after reset", rx_valid, 0);

    // Two-wire framing, strap low, three data bytes (R2, R3, R5).
    pay[0] = 8'hA5; pay[1] = 8'h00; pay[2] = 8'hFF;
    xfer(1'b0, 1'b0, 8'h88, 3);
    // Three-wire framing, strap high (R2, R3).
    pay[0] = 8'h5A; pay[1] = 8'h81;
    xfer(1'b1, 1'b1, 8'h8A, 2);
    // Wrong strap bit and set direction bit: mismatches (R3, R7).
    xfer(1'b1, 1'b1, 8'h88, 2);
    xfer(1'b0, 1'b0, 8'h89, 2);
    // Address only, no data bytes (R5).
    xfer(1'b0, 1'b1, 8'h8A, 0);

    // Restart mid-byte in both framings (R8).
    for (int m = 0; m < 2; m++) begin
      mode3 = (m == 1); addr_sel = 1'b0; tick(P);
      bus_start();
      send_byte(8'h88, ack);
      chk(ack, "R8 first address ack", ack, 1);
      send_bits(8'hF0, 4);
      bus_start();
      send_byte(8'h88, ack);
      chk(ack, "R8 address ack after restart", ack, 1);
      send_byte(8'h3C, ack);
      exp_q.push_back(8'h3C);
      bus_stop(); tick(P);
      compare_rx("R8 partial byte dropped");
    end

    // Stop mid-byte, then a byte clocked without a start (R9).
    mode3 = 1'b0; addr_sel = 1'b1; tick(P);
    bus_start();
    send_byte(8'h8A, ack);
    send_bits(8'hC3, 5);
    bus_stop();
    send_byte(8'h55, ack);
    chk(!ack, "R9 no ack without start", ack, 0);
    bus_stop(); tick(P);
    compare_rx("R9 nothing after stop");

    // Random transfers.
    for (int t = 0; t < 30; t++) begin
      bit m3r;
      bit ar;
      logic [7:0] abr;
      int nb;
      m3r = 1'($urandom % 2);
      ar  = 1'($urandom % 2);
      abr = (($urandom % 5) != 0) ? dev_addr(ar) : 8'($urandom);
      nb  = int'($urandom % 6);
      for (int i = 0; i < 8; i++) pay[i] = 8'($urandom);
      xfer(m3r, ar, abr, nb);
    end

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule